// File: doc/BRIEF.md
# Touch Sensor Calibration Sequencer

This block schedules the measurement bursts of a capacitive touch controller. After reset it runs a calibration series. A host calibrate request starts a shorter series. Once calibration is done, it repeats normal acquisition bursts at a fixed interval. It can put the controller to sleep, and it brings it back either on a wake event or after a long timeout. When an acquisition follows a wake-up, it adds a wake delay and then a settling delay before that burst. Every delay is counted in pulses of a single `tick` input, so a simulation can shrink real time by raising the tick rate. The measurement front end is modelled as a handshake: `burst_start` asks for one burst and `burst_done` reports that the burst is complete.

The sequencer has ten states.
- `ST_CAL_GAP`: counts the gap before the next calibration burst.
- `ST_CAL_FIRE`: issues a calibration burst.
- `ST_CAL_WAIT`: waits for that burst to finish.
- `ST_FLUSH`: drains a burst that was outstanding when a calibrate request arrived.
- `ST_READY`: the host may talk to the controller (`drdy` high) while the acquisition interval counts.
- `ST_ACQ_FIRE` and `ST_ACQ_WAIT`: issue a normal burst and wait for it.
- `ST_SLEEP`: the controller sleeps.
- `ST_WAKE` and `ST_SETTLE`: the two delays after sleep.

The transitions are as follows.
- Reset enters the gap state, with a calibration series of base plus extra bursts loaded.
- Gap expiry leads to fire, and fire always leads to wait.
- In the wait state, `burst_done` leads to the gap state, or to ready after the last burst.
- In ready, a sleep request leads to sleep, and interval expiry leads to acquisition fire.
- Acquisition fire leads to acquisition wait, and `burst_done` there returns to ready.
- A wake event or the sleep timeout leads to wake. Wake expiry leads to settle, and settle expiry leads to acquisition fire.
- A calibrate request overrides every state. It goes to flush if a burst is outstanding, and otherwise to the gap state, with a series of base bursts loaded.
- Flush goes to the gap state on `burst_done`.

`err_flag` reports a calibration that captured a touch. Each calibration clears it and arms a one-shot check. The first acquisition that reports a detection then loads the flag from that detection's inverted-signal indicator.

Top module: `touch_cal_seq`

## Requirements
- R1: After reset `drdy`, `burst_start`, `asleep` and `err_flag` are low. The block then issues CAL_BURSTS+PWRUP_EXTRA calibration bursts, each with `burst_cal` high and the first one GAP_TICKS ticks after reset, before `drdy` first rises.
- R2: A `cal_req` pulse taken while no burst is outstanding starts a series of exactly CAL_BURSTS calibration bursts, the first one GAP_TICKS ticks after the request. `drdy` rises on the cycle after the last burst's `burst_done`.
- R3: Between the `burst_done` of a calibration burst that is not the last and the next `burst_start`, exactly GAP_TICKS ticks are counted.
- R4: `drdy` is low in the cycle after any `cal_req`, throughout every calibration series, and while any burst is outstanding.
- R5: A `cal_req` during a calibration series restarts the count, so CAL_BURSTS bursts follow the latest request. If a burst is outstanding, the series starts only after that burst's `burst_done`, counted from then.
- R6: A `burst_done` pulse while no burst is outstanding is ignored. It starts no burst, does not change `drdy`, and does not advance the calibration count.
- R7: From ready, an acquisition burst (`burst_cal` low) starts ACQ_TICKS ticks after the previous burst's `burst_done`. No settling delay is added.
- R8: `sleep_req` in ready sets `asleep` and drops `drdy`. A `wake_evt` while asleep, or SLEEP_TICKS ticks of sleep, ends sleep. The next acquisition then starts WAKE_TICKS+SETTLE_TICKS ticks after the wake point.
- R9: `cal_req` clears `err_flag`. Only the first acquisition after a calibration whose `burst_done` carries `det_valid` high loads `err_flag` from `det_inverted`. Later detections leave it unchanged.
- R10: `burst_start` lasts one cycle, and at most one burst is outstanding at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; acts as power-up |
| tick | input | 1 | Timebase strobe, one cycle per time unit |
| cal_req | input | 1 | Host calibrate request pulse |
| sleep_req | input | 1 | Request to enter sleep, honoured in ready |
| wake_evt | input | 1 | Wake event (host select), honoured while asleep |
| burst_done | input | 1 | Front end reports the burst finished |
| det_valid | input | 1 | With burst_done: a touch was detected |
| det_inverted | input | 1 | With burst_done: the detection signal had inverted sign |
| burst_start | output | 1 | One-cycle request to start a burst |
| burst_cal | output | 1 | High with burst_start when the burst is a calibration burst |
| drdy | output | 1 | Data ready: host may communicate |
| asleep | output | 1 | Controller is in sleep |
| err_flag | output | 1 | Calibration error indication |

## Verification
The bench counts ticks between each completed burst, or each wake point, and the following burst start. Its reference model works out which delay applies to that burst. A design that added the settling delay without a preceding sleep, or that counted the tick on the transition edge, would miss by one or more ticks. A calibrate request is driven while a burst is outstanding, and again in the middle of a series. A design that counted the stale completion as a calibration burst, or that kept the old count, would raise `drdy` too early. A spurious completion is injected during a calibration gap. Detections with both polarities show whether the error flag is latched only by the first detection after a calibration.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    typedef enum logic [3:0] {
        ST_CAL_GAP,
        ST_CAL_FIRE,
        ST_CAL_WAIT,
        ST_FLUSH,
        ST_READY,
        ST_ACQ_FIRE,
        ST_ACQ_WAIT,
        ST_SLEEP,
        ST_WAKE,
        ST_SETTLE
    } seq_state_e;

endpackage

// File: rtl/tcs_tick_timer.sv
module tcs_tick_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The Nth tick seen since the phase began ends the phase.
    assign done = tick && (cnt_q == limit - 1'b1);

endmodule

// File: rtl/tcs_burst_count.sv
module tcs_burst_count #(
    parameter int BW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [BW-1:0] total,
    output logic          last
);

    logic [BW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == total - 1'b1);

endmodule

// File: rtl/tcs_err_track.sv
module tcs_err_track (
    input  logic clk,
    input  logic rst_n,
    input  logic cal_start,
    input  logic det_strobe,
    input  logic det_inverted,
    output logic err
);

    logic armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err     <= 1'b0;
            armed_q <= 1'b1;
        end else if (cal_start) begin
            err     <= 1'b0;
            armed_q <= 1'b1;
        end else if (det_strobe && armed_q) begin
            err     <= det_inverted;
            armed_q <= 1'b0;
        end
    end

endmodule

// File: rtl/touch_cal_seq.sv
module touch_cal_seq
    import tcs_pkg::*;
#(
    parameter int CAL_BURSTS   = 10,
    parameter int PWRUP_EXTRA  = 6,
    parameter int GAP_TICKS    = 1000,
    parameter int WAKE_TICKS   = 400,
    parameter int SETTLE_TICKS = 500,
    parameter int ACQ_TICKS    = 20000,
    parameter int SLEEP_TICKS  = 3000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cal_req,
    input  logic sleep_req,
    input  logic wake_evt,
    input  logic burst_done,
    input  logic det_valid,
    input  logic det_inverted,
    output logic burst_start,
    output logic burst_cal,
    output logic drdy,
    output logic asleep,
    output logic err_flag
);

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int T_MAX = max2(max2(max2(GAP_TICKS, WAKE_TICKS), max2(SETTLE_TICKS, ACQ_TICKS)), SLEEP_TICKS);
    localparam int TW    = $clog2(T_MAX + 1);
    localparam int B_MAX = CAL_BURSTS + PWRUP_EXTRA;
    localparam int BW    = $clog2(B_MAX + 1);

    seq_state_e state_q, state_d;

    logic          t_done;
    logic          t_clr;
    logic [TW-1:0] t_limit;
    logic          b_last;
    logic          b_inc;
    logic [BW-1:0] cal_total_q;
    logic          busy_burst;
    logic          det_strobe;

    // A burst is outstanding in the fire, wait and flush states.
    assign busy_burst = (state_q == ST_CAL_FIRE) || (state_q == ST_CAL_WAIT) ||
                        (state_q == ST_ACQ_FIRE) || (state_q == ST_ACQ_WAIT) ||
                        (state_q == ST_FLUSH);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CAL_GAP;
        end else begin
            state_q <= state_d;
        end
    end

    // Series length: power-up series at reset, command series on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_total_q <= BW'(B_MAX);
        end else if (cal_req) begin
            cal_total_q <= BW'(CAL_BURSTS);
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (cal_req) begin
            if ((state_q == ST_CAL_FIRE) || (state_q == ST_ACQ_FIRE)) begin
                state_d = ST_FLUSH;
            end else if (busy_burst && !burst_done) begin
                state_d = ST_FLUSH;
            end else begin
                state_d = ST_CAL_GAP;
            end
        end else begin
            unique case (state_q)
                ST_CAL_GAP:  if (t_done) state_d = ST_CAL_FIRE;
                ST_CAL_FIRE: state_d = ST_CAL_WAIT;
                ST_CAL_WAIT: if (burst_done) state_d = b_last ? ST_READY : ST_CAL_GAP;
                ST_FLUSH:    if (burst_done) state_d = ST_CAL_GAP;
                ST_READY: begin
                    if (sleep_req) begin
                        state_d = ST_SLEEP;
                    end else if (t_done) begin
                        state_d = ST_ACQ_FIRE;
                    end
                end
                ST_ACQ_FIRE: state_d = ST_ACQ_WAIT;
                ST_ACQ_WAIT: if (burst_done) state_d = ST_READY;
                ST_SLEEP:    if (wake_evt || t_done) state_d = ST_WAKE;
                ST_WAKE:     if (t_done) state_d = ST_SETTLE;
                ST_SETTLE:   if (t_done) state_d = ST_ACQ_FIRE;
                default:     state_d = ST_CAL_GAP;
            endcase
        end
    end

    // Delay length for the current timed state
    always_comb begin
        t_limit = TW'(1);
        unique case (state_q)
            ST_CAL_GAP: t_limit = TW'(GAP_TICKS);
            ST_READY:   t_limit = TW'(ACQ_TICKS);
            ST_SLEEP:   t_limit = TW'(SLEEP_TICKS);
            ST_WAKE:    t_limit = TW'(WAKE_TICKS);
            ST_SETTLE:  t_limit = TW'(SETTLE_TICKS);
            default:    t_limit = TW'(1);
        endcase
    end

    // Outputs
    always_comb begin
        burst_start = 1'b0;
        burst_cal   = 1'b0;
        drdy        = 1'b0;
        asleep      = 1'b0;
        unique case (state_q)
            ST_CAL_FIRE: begin
                burst_start = 1'b1;
                burst_cal   = 1'b1;
            end
            ST_ACQ_FIRE: burst_start = 1'b1;
            ST_READY:    drdy = 1'b1;
            ST_SLEEP:    asleep = 1'b1;
            default: begin
                burst_start = 1'b0;
            end
        endcase
    end

    assign t_clr      = (state_d != state_q) || cal_req;
    assign b_inc      = (state_q == ST_CAL_WAIT) && burst_done && !cal_req;
    assign det_strobe = (state_q == ST_ACQ_WAIT) && burst_done && det_valid;

    tcs_tick_timer #(.CW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (t_clr),
        .tick  (tick),
        .limit (t_limit),
        .done  (t_done)
    );

    tcs_burst_count #(.BW(BW)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cal_req),
        .inc   (b_inc),
        .total (cal_total_q),
        .last  (b_last)
    );

    tcs_err_track u_err (
        .clk          (clk),
        .rst_n        (rst_n),
        .cal_start    (cal_req),
        .det_strobe   (det_strobe),
        .det_inverted (det_inverted),
        .err          (err_flag)
    );

endmodule

// File: rtl/touch_cal_seq_chk.sv
module touch_cal_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cal_req,
    input logic burst_done,
    input logic burst_start,
    input logic burst_cal,
    input logic drdy,
    input logic asleep,
    input logic err_flag
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (burst_start) begin
            pend_q <= 1'b1;
        end else if (burst_done) begin
            pend_q <= 1'b0;
        end
    end

    // R10
    burst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> !burst_start);

    // R10
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |-> !pend_q);

    // R4
    cal_drops_drdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_req |=> !drdy);

    // R4
    busy_no_drdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !drdy);

    // R1
    cal_burst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_cal |-> (burst_start && !drdy && !asleep));

    // R9
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(burst_done));

    // R9
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_req |=> !err_flag);

    // R8
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> (!drdy && !burst_start));

endmodule

bind touch_cal_seq touch_cal_seq_chk u_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cal_req     (cal_req),
    .burst_done  (burst_done),
    .burst_start (burst_start),
    .burst_cal   (burst_cal),
    .drdy        (drdy),
    .asleep      (asleep),
    .err_flag    (err_flag)
);

// File: tb/tb_touch_cal_seq.sv
`timescale 1ns/1ps
module tb_touch_cal_seq;

    localparam int CAL    = 10;
    localparam int EXTRA  = 6;
    localparam int GAP    = 3;
    localparam int WAKE   = 4;
    localparam int SETTLE = 5;
    localparam int ACQ    = 6;
    localparam int SLP    = 20;
    localparam int TDIV   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic cal_req = 1'b0;
    logic sleep_req = 1'b0;
    logic wake_evt = 1'b0;
    logic burst_done = 1'b0;
    logic det_valid = 1'b0;
    logic det_inverted = 1'b0;
    logic burst_start, burst_cal, drdy, asleep, err_flag;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    touch_cal_seq #(
        .CAL_BURSTS(CAL), .PWRUP_EXTRA(EXTRA), .GAP_TICKS(GAP),
        .WAKE_TICKS(WAKE), .SETTLE_TICKS(SETTLE), .ACQ_TICKS(ACQ),
        .SLEEP_TICKS(SLP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cal_req(cal_req),
        .sleep_req(sleep_req), .wake_evt(wake_evt), .burst_done(burst_done),
        .det_valid(det_valid), .det_inverted(det_inverted),
        .burst_start(burst_start), .burst_cal(burst_cal), .drdy(drdy),
        .asleep(asleep), .err_flag(err_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // Tick timebase
    initial begin
        forever begin
            repeat (TDIV - 1) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    // Front-end responder
    initial begin
        forever begin
            @(negedge clk);
            if (burst_start) begin
                repeat (1 + ($urandom % 4)) @(negedge clk);
                burst_done = 1'b1;
                @(negedge clk);
                burst_done = 1'b0;
            end
        end
    end

    // Reference model and monitor
    bit    m_pend, m_flush, m_calph, m_last_cal, m_err, m_armed, m_restart;
    bit    prev_drdy, prev_asleep, ev;
    int    cnt, exp_t, n_cal, target;
    string kind;

    function automatic int delay_for(input bit calph, input int ncal, input int tgt);
        return (calph && ncal < tgt) ? GAP : ACQ;
    endfunction

    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            m_pend = 0; m_flush = 0; m_calph = 1; m_last_cal = 0;
            m_err = 0; m_armed = 1; m_restart = 0;
            cnt = 0; exp_t = GAP; kind = "R1"; n_cal = 0; target = CAL + EXTRA;
            prev_drdy = 0; prev_asleep = 0;
        end else begin
            ev = 0;
            if (cal_req) begin
                m_restart = m_calph;
                m_err = 0; m_armed = 1; m_calph = 1; n_cal = 0; target = CAL;
                ev = 1; cnt = 0;
                if (m_pend && !burst_done) begin
                    m_flush = 1; exp_t = -1;
                end else begin
                    m_pend = 0; m_flush = 0; exp_t = GAP; kind = "R2";
                end
            end else if (burst_done && m_pend) begin
                m_pend = 0; ev = 1; cnt = 0;
                if (m_flush) begin
                    m_flush = 0; exp_t = GAP; kind = "R5";
                end else if (m_last_cal) begin
                    exp_t = delay_for(m_calph, n_cal, target);
                    kind = (exp_t == GAP) ? "R3" : "R7";
                end else begin
                    exp_t = ACQ; kind = "R7";
                    if (det_valid && m_armed) begin
                        m_err = det_inverted; m_armed = 0;
                    end
                    check(err_flag == m_err, "R9 err after detection", err_flag, m_err);
                end
            end else if (burst_done && !m_pend) begin
                check(!burst_start && drdy == prev_drdy, "R6 stray done",
                      {burst_start, drdy}, {1'b0, prev_drdy});
            end
            if (!cal_req && sleep_req && prev_drdy) begin
                ev = 1; cnt = 0; exp_t = SLP + WAKE + SETTLE; kind = "R8";
                check(asleep && !drdy, "R8 enter sleep", {asleep, drdy}, 2);
            end
            if (!cal_req && wake_evt && prev_asleep) begin
                ev = 1; cnt = 0; exp_t = WAKE + SETTLE; kind = "R8";
                check(!asleep, "R8 wake event", asleep, 0);
            end
            if (!ev && tick) cnt++;
            if (burst_start) begin
                check(burst_cal == m_calph, "R1 burst type", burst_cal, m_calph);
                if (exp_t >= 0) check(cnt == exp_t, {kind, " tick spacing"}, cnt, exp_t);
                m_pend = 1; m_last_cal = burst_cal;
                if (burst_cal) n_cal++;
                exp_t = -1;
            end
            if (drdy && !prev_drdy && m_calph) begin
                if (target == CAL + EXTRA)
                    check(n_cal == target, "R1 power-up burst count", n_cal, target);
                else if (m_restart)
                    check(n_cal == target, "R5 restarted burst count", n_cal, target);
                else
                    check(n_cal == target, "R2 command burst count", n_cal, target);
                check(err_flag == m_err, "R9 flag after calibration", err_flag, m_err);
                m_calph = 0;
            end
            if (m_calph && drdy) check(0, "R4 drdy during calibration", 1, 0);
            prev_drdy = drdy; prev_asleep = asleep;
        end
    end

    task automatic pulse(ref logic sig);
        @(negedge clk);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic wait_ready();
        @(negedge clk);
        while (!drdy) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (6) @(negedge clk);
        // R1 reset state
        check({drdy, burst_start, asleep, err_flag} == 4'b0, "R1 reset outputs",
              {drdy, burst_start, asleep, err_flag}, 0);
        rst_n = 1'b1;
        wait_ready();
        repeat (60) @(negedge clk);

        // R9: first detection after calibration is inverted, later one is not
        det_valid = 1'b1; det_inverted = 1'b1;
        repeat (80) @(negedge clk);
        det_inverted = 1'b0;
        repeat (80) @(negedge clk);
        check(err_flag == 1'b1, "R9 flag kept", err_flag, 1);

        // R8 automatic wake
        wait_ready();
        pulse(sleep_req);
        repeat (200) @(negedge clk);

        // R8 wake event
        wait_ready();
        pulse(sleep_req);
        repeat (20) @(negedge clk);
        pulse(wake_evt);
        repeat (100) @(negedge clk);

        // R2 command calibration with R6 stray completion in the gap
        wait_ready();
        pulse(cal_req);
        pulse(burst_done);
        check(!drdy, "R4 drdy low in calibration", drdy, 0);
        wait_ready();

        // R5 restart in mid-series
        pulse(cal_req);
        begin
            int seen = 0;
            while (seen < 4) begin
                @(negedge clk);
                if (burst_start && burst_cal) seen++;
            end
        end
        pulse(cal_req);
        wait_ready();

        // R5 request while an acquisition is outstanding
        @(negedge clk);
        while (!(burst_start && !burst_cal)) @(negedge clk);
        cal_req = 1'b1;
        @(negedge clk);
        cal_req = 1'b0;
        wait_ready();

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int r;
            repeat ($urandom % 40) @(negedge clk);
            r = $urandom % 12;
            case (r)
                0: pulse(cal_req);
                1, 2: pulse(sleep_req);
                3, 4, 5: pulse(wake_evt);
                6: begin det_valid = $urandom % 2; det_inverted = $urandom % 2; end
                default: @(negedge clk);
            endcase
        end
        wait_ready();
        repeat (20) @(negedge clk);
        finish_run();
    end

endmodule